// File: doc/BRIEF.md
# Supply Monitor Control Register

This block is an 8-bit control and status register for a supply-voltage monitor. Two analog comparators report, as digital levels, that the supply is below a warning threshold or below a detect threshold. Each level goes through a two-flop synchronizer. The warning level feeds a sticky flag that software clears by writing a one to an acknowledge bit. That flag can raise an interrupt request.

The detect level can request a chip reset. It does so only once the detect logic is enabled, and both that enable and the reset enable accept only the first register write after reset. In stop mode a detect event is ignored unless a separate read/write bit keeps detection running. Two further bits drive the enable and drive strength of a reference buffer.

Software writes the register with a one-cycle write strobe and a data byte. The current contents are always visible on the read bus.

Top module: `lvmon_ctrl`

## Requirements
- R1: After reset, every stored bit is 0. The read bus is 0x00 while the warning input is low, and irq_o, rst_req_o, buf_en_o and buf_hidrive_o are 0.
- R2: Read bit 7 is the warning flag. It reads 1 on the third rising edge after warn_lvl_i goes high, and this includes a warning that is already present when reset is released.
- R3: The flag is sticky. Writing a byte with bit 6 set clears the flag only if the synchronized warning level is low. Writing bit 7 has no effect. Read bit 6 always reads 0.
- R4: irq_o is 1 exactly while the flag is 1 and read/write bit 5 (interrupt enable) is 1.
- R5: Bit 2 (detect enable) and bit 4 (detect-reset enable) take their values from the first write after reset. A single write locks both bits, and later writes leave them unchanged.
- R6: Bits 5, 3, 1 and 0 follow every write.
- R7: With bits 2 and 4 both 1, a rise of det_lvl_i produces a one-cycle rst_req_o pulse on the third rising edge. The pulse does not repeat while the level stays high, and a new rise gives a new pulse.
- R8: While stop_i is 1, detect events give no pulse unless bit 3 (detect in stop) is 1.
- R9: With bit 2 at 0, detect events never produce rst_req_o, whatever bit 4 holds.
- R10: buf_en_o equals bit 0. buf_hidrive_o equals bit 1 while bit 0 is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| warn_lvl_i | input | 1 | Comparator level, 1 = supply below warning threshold |
| det_lvl_i | input | 1 | Comparator level, 1 = supply below detect threshold |
| stop_i | input | 1 | Stop mode active |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data |
| irq_o | output | 1 | Warning interrupt request |
| rst_req_o | output | 1 | One-cycle reset request |
| buf_en_o | output | 1 | Reference buffer enable |
| buf_hidrive_o | output | 1 | Reference buffer high-drive select |

## Verification
The acknowledge path is tried twice: once while the warning is still asserted, where the flag must survive, and once after the warning has gone, where it must clear. A write of bit 7 alone must leave the flag set, which separates a true acknowledge from a plain register write. The write-once pair is checked by a first write, then an all-zero write and a mixed write. Only the first write may change bits 4 and 2, while the neighbouring free bits must still follow every write. Detect behaviour is tried with the level held high, toggled, gated by stop with and without the stop enable, and with reset enabled but detection locked off. These cases separate an edge-triggered, qualified request from a level-driven or unqualified one.

// File: rtl/lvmon_ctrl.sv
module lvmon_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       warn_lvl_i,
  input  logic       det_lvl_i,
  input  logic       stop_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  output logic       irq_o,
  output logic       rst_req_o,
  output logic       buf_en_o,
  output logic       buf_hidrive_o
);

  logic [1:0] warn_sync, det_sync;
  logic warn_s, det_s;
  logic flag, irq_en, det_rst_en, det_stop_en, det_en, hi_drv, buf_on;
  logic det_en_locked, det_rst_locked;
  logic det_qual, det_qual_q;
  logic ack_req;
  logic unused_bit7;

  assign unused_bit7 = wr_data_i[7];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      warn_sync <= 2'b00;
      det_sync  <= 2'b00;
    end else begin
      warn_sync <= {warn_sync[0], warn_lvl_i};
      det_sync  <= {det_sync[0], det_lvl_i};
    end

  assign warn_s  = warn_sync[1];
  assign det_s   = det_sync[1];
  assign ack_req = wr_en_i & wr_data_i[6];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               flag <= 1'b0;
    else if (warn_s)          flag <= 1'b1;
    else if (ack_req)         flag <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq_en      <= 1'b0;
      det_stop_en <= 1'b0;
      hi_drv      <= 1'b0;
      buf_on      <= 1'b0;
    end else if (wr_en_i) begin
      irq_en      <= wr_data_i[5];
      det_stop_en <= wr_data_i[3];
      hi_drv      <= wr_data_i[1];
      buf_on      <= wr_data_i[0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      det_en        <= 1'b0;
      det_en_locked <= 1'b0;
    end else if (wr_en_i && !det_en_locked) begin
      det_en        <= wr_data_i[2];
      det_en_locked <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      det_rst_en     <= 1'b0;
      det_rst_locked <= 1'b0;
    end else if (wr_en_i && !det_rst_locked) begin
      det_rst_en     <= wr_data_i[4];
      det_rst_locked <= 1'b1;
    end

  assign det_qual = det_en & det_s & (~stop_i | det_stop_en);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      det_qual_q <= 1'b0;
      rst_req_o  <= 1'b0;
    end else begin
      det_qual_q <= det_qual;
      rst_req_o  <= det_qual & ~det_qual_q & det_rst_en;
    end

  assign rd_data_o     = {flag, 1'b0, irq_en, det_rst_en, det_stop_en, det_en, hi_drv, buf_on};
  assign irq_o         = flag & irq_en;
  assign buf_en_o      = buf_on;
  assign buf_hidrive_o = buf_on & hi_drv;

endmodule

// File: rtl/lvmon_ctrl_chk.sv
module lvmon_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en_i,
  input logic       ack_bit_i,
  input logic [7:0] rd_data_o,
  input logic       irq_o,
  input logic       rst_req_o,
  input logic       buf_en_o,
  input logic       buf_hidrive_o
);

  logic wrote_once;
  logic unused_rd;
  assign unused_rd = ^{rd_data_o[3], rd_data_o[1:0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       wrote_once <= 1'b0;
    else if (wr_en_i) wrote_once <= 1'b1;

  // R3
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[7] && !(wr_en_i && ack_bit_i) |=> rd_data_o[7]);

  // R3
  ack_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data_o[6]);

  // R4
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> rd_data_o[7] && rd_data_o[5]);

  // R5
  write_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrote_once && wr_en_i |=> $stable(rd_data_o[2]) && $stable(rd_data_o[4]));

  // R7
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);

  // R9
  rst_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> rd_data_o[2] && rd_data_o[4]);

  // R10
  hidrive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_hidrive_o |-> buf_en_o);

endmodule

bind lvmon_ctrl lvmon_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .ack_bit_i(wr_data_i[6]),
  .rd_data_o(rd_data_o), .irq_o(irq_o), .rst_req_o(rst_req_o),
  .buf_en_o(buf_en_o), .buf_hidrive_o(buf_hidrive_o)
);

// File: tb/sim_lvmon_ctrl.sv
module sim_lvmon_ctrl;
  logic clk = 0, rst_n = 0;
  logic warn_lvl_i = 0, det_lvl_i = 0, stop_i = 0, wr_en_i = 0;
  logic [7:0] wr_data_i = 0;
  logic [7:0] rd_data_o;
  logic irq_o, rst_req_o, buf_en_o, buf_hidrive_o;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  lvmon_ctrl u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset(input logic warn);
    rst_n = 0; warn_lvl_i = warn; det_lvl_i = 0; stop_i = 0; wr_en_i = 0;
    clks(2);
    rst_n = 1;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en_i = 1; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 0; wr_data_i = 0;
  endtask

  task automatic count_pulses(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rst_req_o) cnt++;
    end
  endtask

  task automatic t_reset;
    do_reset(0);
    clks(4);
    chk("R1 rd", rd_data_o, 8'h00);
    chk("R1 outs", {irq_o, rst_req_o, buf_en_o, buf_hidrive_o}, 0);
  endtask

  task automatic t_flag_at_start;
    do_reset(1);
    clks(2);
    chk("R2 flag before 3 edges", rd_data_o[7], 0);
    clks(1);
    chk("R2 flag after 3 edges", rd_data_o[7], 1);
  endtask

  task automatic t_ack;
    wr(8'h40);
    chk("R3 ack while active", rd_data_o[7], 1);
    warn_lvl_i = 0;
    clks(4);
    chk("R3 sticky", rd_data_o[7], 1);
    wr(8'h80);
    chk("R3 bit7 write ignored", rd_data_o[7], 1);
    wr(8'h40);
    chk("R3 ack clears", rd_data_o[7], 0);
    chk("R3 ack reads 0", rd_data_o[6], 0);
  endtask

  task automatic t_irq;
    do_reset(0);
    wr(8'h20);
    clks(1);
    chk("R4 no flag no irq", irq_o, 0);
    warn_lvl_i = 1;
    clks(3);
    chk("R4 irq on", irq_o, 1);
    wr(8'h00);
    chk("R4 irq off when disabled", irq_o, 0);
    chk("R4 flag kept", rd_data_o[7], 1);
    warn_lvl_i = 0;
  endtask

  task automatic t_once;
    do_reset(0);
    wr(8'h14);
    chk("R5 first write", rd_data_o, 8'h14);
    wr(8'h00);
    chk("R5 later zero ignored", rd_data_o, 8'h14);
    wr(8'h2B);
    chk("R6 free bits follow", rd_data_o, 8'h3F);
    wr(8'h00);
    chk("R6 free bits clear", rd_data_o, 8'h14);
  endtask

  task automatic t_detect;
    int n;
    do_reset(0);
    wr(8'h14);
    det_lvl_i = 1;
    clks(2);
    chk("R7 not before 3 edges", rst_req_o, 0);
    clks(1);
    chk("R7 pulse", rst_req_o, 1);
    clks(1);
    chk("R7 one cycle", rst_req_o, 0);
    count_pulses(6, n);
    chk("R7 no repeat on level", n, 0);
    det_lvl_i = 0;
    clks(4);
    det_lvl_i = 1;
    count_pulses(6, n);
    chk("R7 new rise new pulse", n, 1);
    det_lvl_i = 0;
  endtask

  task automatic t_stop;
    int n;
    do_reset(0);
    wr(8'h14);
    stop_i = 1;
    det_lvl_i = 1;
    count_pulses(8, n);
    chk("R8 gated in stop", n, 0);
    wr(8'h1C);
    count_pulses(4, n);
    chk("R8 stop enable allows", n, 1);
    stop_i = 0; det_lvl_i = 0;
  endtask

  task automatic t_disabled;
    int n;
    do_reset(0);
    wr(8'h10);
    wr(8'h14);
    chk("R9 detect enable locked off", rd_data_o[2], 0);
    det_lvl_i = 1;
    count_pulses(8, n);
    chk("R9 no reset without detect enable", n, 0);
    det_lvl_i = 0;
  endtask

  task automatic t_buf;
    do_reset(0);
    wr(8'h02);
    chk("R10 hi without en", {buf_en_o, buf_hidrive_o}, 2'b00);
    wr(8'h03);
    chk("R10 en hi", {buf_en_o, buf_hidrive_o}, 2'b11);
    wr(8'h01);
    chk("R10 en lo", {buf_en_o, buf_hidrive_o}, 2'b10);
  endtask

  initial begin
    t_reset();
    t_flag_at_start();
    t_ack();
    t_irq();
    t_once();
    t_detect();
    t_stop();
    t_disabled();
    t_buf();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule